// File: doc/BRIEF.md
# Bang-Bang Delay-Tap Phase Tracker

This block is the digital half of a zero-crossing phase tracking loop. An external delay line provides a set of evenly spaced copies of a reference clock that together cover one full period. A multiplexer picks one of them to clock a comparator, and the comparator reports whether the intermediate-frequency input was above or below zero at that edge. The tracker reads that one-bit decision and moves a tap index one code later or one code earlier. The index drives the multiplexer select. The index also serves as the phase measurement, and a downstream averager can accumulate it to refine the estimate.

The comparator bit comes from another timing domain, so it passes through a short synchronizer chain first. To keep each step based on a decision taken at the tap that is currently selected, the tracker works in rounds. A round holds the tap steady for one sampling cycle plus the synchronizer depth. At the end of the round the index moves by exactly one position, modulo the tap count, and a valid strobe marks the new value for one cycle. Once the loop is locked onto the input's rising zero crossing, the index alternates between the two codes that bracket it.

The tap index is held in a register, so the select never shows intermediate bit patterns. Dropping the enable freezes the index and restarts the round.

Top module: `bb_phase_tracker`

## Requirements
- R1: A synchronous reset, active high, sets the tap index to 0 and the valid strobe to 0.
- R2: A comparator level of 0 (signal still below zero at the selected edge, so the input lags) makes the round end with the index one code higher.
- R3: A comparator level of 1 (signal already above zero, so the input leads) makes the round end with the index one code lower.
- R4: The index wraps modulo TAPS. A step up from TAPS-1 gives 0, and a step down from 0 gives TAPS-1.
- R5: While the enable is low, the index holds its value and the valid strobe stays 0, whatever the comparator does.
- R6: A round lasts SYNC_STAGES+1 consecutive enabled cycles (3 by default). The index changes only on the last edge of a round and by exactly one code. A low enable restarts the count, so the first step after enable rises comes on its third rising edge.
- R7: The valid strobe is 1 for exactly the one cycle that follows each index change, and 0 otherwise.
- R8: The direction of a step is set only by the comparator level captured on the first rising edge of its round. Levels present at the later edges of the round have no effect on it.
- R9: With a comparator that reports 1 when the selected tap lies within half a period after the input's rising crossing at tap P, and 0 otherwise, the index reaches the window {P-1, P} within (TAPS/2+2)*(SYNC_STAGES+1) enabled cycles from reset, for every P. It then stays inside that window and visits both codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Tracking enable; low freezes the index and restarts the round |
| cmp_in | input | 1 | Comparator decision: 1 means the input was above zero at the selected edge |
| tap_sel | output | $clog2(TAPS) | Registered tap index, also the phase measurement |
| smp_vld | output | 1 | One-cycle strobe marking a freshly stepped index |

## Verification
The properties assume that the comparator level depends only on the tap that was selected when it was captured. They also assume that the level does not change across a round in any way that matters, since only the first-edge capture of each round is ever used. The bench changes the comparator and the enable only at falling clock edges. Its analog model recomputes the decision from the registered tap, which is held for the whole round, so every captured level belongs to the current tap. A separate directed case deliberately flips the level after the first edge to show that later levels are discarded.

// File: rtl/ptrk_pkg.sv
package ptrk_pkg;

  typedef enum logic {
    STEP_DN = 1'b0,
    STEP_UP = 1'b1
  } step_dir_e;

  // Modular one-code move of a tap index on a ring of ntaps positions.
  function automatic int unsigned wrap_step(input int unsigned cur,
                                            input step_dir_e dir,
                                            input int unsigned ntaps);
    if (dir == STEP_UP) begin
      return (cur + 1 >= ntaps) ? 0 : cur + 1;
    end
    return (cur == 0) ? ntaps - 1 : cur - 1;
  endfunction

endpackage

// File: rtl/ptrk_sync.sv
module ptrk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ptrk_round.sv
module ptrk_round #(
  parameter int RND = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic step_fire
);

  localparam int CNT_W = $clog2(RND + 1);

  logic [CNT_W-1:0] cnt_q;

  assign step_fire = en && (cnt_q == CNT_W'(RND - 1));

  always_ff @(posedge clk) begin
    if (rst || !en)     cnt_q <= '0;
    else if (step_fire) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/ptrk_tap_reg.sv
module ptrk_tap_reg
  import ptrk_pkg::*;
#(
  parameter int TAPS  = 128,
  parameter int TAP_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             up,
  output logic [TAP_W-1:0] tap_q,
  output logic             vld_q
);

  logic [TAP_W-1:0] tap_nx;

  assign tap_nx = TAP_W'(wrap_step(int'(tap_q), step_dir_e'(up), TAPS));

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= step;
      if (step) tap_q <= tap_nx;
    end
  end

endmodule

// File: rtl/bb_phase_tracker.sv
module bb_phase_tracker #(
  parameter int TAPS        = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    cmp_in,
  output logic [$clog2(TAPS)-1:0] tap_sel,
  output logic                    smp_vld
);

  localparam int TAP_W = $clog2(TAPS);
  localparam int RND   = SYNC_STAGES + 1;

  logic cmp_sync;
  logic step_fire;
  logic dir_up;

  ptrk_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (cmp_in),
    .q   (cmp_sync)
  );

  ptrk_round #(.RND(RND)) round_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .step_fire (step_fire)
  );

  // Below zero at the chosen edge: input lags, pick a later tap.
  assign dir_up = ~cmp_sync;

  ptrk_tap_reg #(.TAPS(TAPS), .TAP_W(TAP_W)) tap_i (
    .clk   (clk),
    .rst   (rst),
    .step  (step_fire),
    .up    (dir_up),
    .tap_q (tap_sel),
    .vld_q (smp_vld)
  );

endmodule

// File: rtl/bb_phase_tracker_chk.sv
module bb_phase_tracker_chk #(
  parameter int TAPS  = 128,
  parameter int TAP_W = 7,
  parameter int RND   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [TAP_W-1:0] tap_sel,
  input logic             smp_vld,
  input logic             step_fire,
  input logic             dir_up
);

  logic             rst_d = 1'b0;
  logic [TAP_W-1:0] prev_tap;
  int               gap;
  int               fwd;

  always_ff @(posedge clk) begin
    rst_d    <= rst;
    prev_tap <= tap_sel;
    if (rst || !en || step_fire) gap <= 0;
    else                         gap <= gap + 1;
  end

  assign fwd = (int'(tap_sel) - int'(prev_tap) + TAPS) % TAPS;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst_d |-> (tap_sel == '0 && !smp_vld));

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (tap_sel == $past(tap_sel) && !smp_vld));

  // R6
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_d |-> (fwd == 0 || fwd == 1 || fwd == TAPS - 1));

  // R6
  round_length_chk: assert property (@(posedge clk) disable iff (rst)
    step_fire |-> (gap == RND - 1));

  // R7
  vld_after_step_chk: assert property (@(posedge clk) disable iff (rst)
    step_fire |=> smp_vld);

  // R7
  vld_only_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld |-> $past(step_fire));

  // R2
  up_direction_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && $past(dir_up)) |-> (fwd == 1));

  // R3
  down_direction_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !$past(dir_up)) |-> (fwd == TAPS - 1));

endmodule

bind bb_phase_tracker bb_phase_tracker_chk #(
  .TAPS  (TAPS),
  .TAP_W (TAP_W),
  .RND   (RND)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .tap_sel   (tap_sel),
  .smp_vld   (smp_vld),
  .step_fire (step_fire),
  .dir_up    (dir_up)
);

// File: tb/bb_phase_tracker_tb_top.sv
module bb_phase_tracker_tb_top;

  localparam int CLK_NS     = 10;
  localparam int TAPS       = 128;
  localparam int SYNC       = 2;
  localparam int RND        = SYNC + 1;
  localparam int LOCK_LIMIT = (TAPS / 2 + 2) * RND;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic       cmp_in;
  logic [6:0] tap_sel;
  logic       smp_vld;

  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  bit   model_on = 1'b0;
  int   phase  = 0;
  logic forced = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  // Analog stand-in: high when the tap lies in the half period after the crossing.
  function automatic logic model_cmp(input int t, input int p);
    int d;
    d = ((t - p) % TAPS + TAPS) % TAPS;
    return d < TAPS / 2;
  endfunction

  always_comb cmp_in = model_on ? model_cmp(int'(tap_sel), phase) : forced;

  bb_phase_tracker #(.TAPS(TAPS), .SYNC_STAGES(SYNC)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .cmp_in  (cmp_in),
    .tap_sel (tap_sel),
    .smp_vld (smp_vld)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0; model_on = 1'b0; forced = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Runs one full round from a negedge with en high; checks quiet edges then the step.
  task automatic run_round(input string req, input int start, input int exp);
    for (int i = 0; i < RND - 1; i++) begin
      @(posedge clk); @(negedge clk);
      check_eq({req, " R6 mid-round tap"}, int'(tap_sel), start);
      check_eq({req, " R7 mid-round valid"}, int'(smp_vld), 0);
    end
    @(posedge clk); @(negedge clk);
    check_eq({req, " step tap"}, int'(tap_sel), exp);
    check_eq({req, " R7 valid"}, int'(smp_vld), 1);
  endtask

  task automatic t_reset();
    do_reset();
    check_eq("R1 tap", int'(tap_sel), 0);
    check_eq("R1 valid", int'(smp_vld), 0);
  endtask

  task automatic t_up_down();
    do_reset();
    forced = 1'b0; en = 1'b1;
    for (int k = 1; k <= 5; k++) run_round("R2", k - 1, k);
    en = 1'b0;
    @(posedge clk); @(negedge clk);
    forced = 1'b1; en = 1'b1;
    run_round("R3", 5, 4);
    run_round("R3", 4, 3);
    en = 1'b0;
  endtask

  task automatic t_wrap();
    do_reset();
    forced = 1'b1; en = 1'b1;
    run_round("R4 down-wrap", 0, TAPS - 1);
    forced = 1'b0;
    run_round("R4 up-wrap", TAPS - 1, 0);
    en = 1'b0;
  endtask

  task automatic t_hold();
    do_reset();
    forced = 1'b0; en = 1'b1;
    @(posedge clk); @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      forced = ~forced;
      @(posedge clk); @(negedge clk);
      check_eq("R5 held tap", int'(tap_sel), 0);
      check_eq("R5 valid low", int'(smp_vld), 0);
    end
    forced = 1'b0; en = 1'b1;
    @(posedge clk); @(negedge clk);
    check_eq("R6 restart edge1", int'(tap_sel), 0);
    @(posedge clk); @(negedge clk);
    check_eq("R6 restart edge2", int'(tap_sel), 0);
    @(posedge clk); @(negedge clk);
    check_eq("R6 restart edge3", int'(tap_sel), 1);
    en = 1'b0;
  endtask

  task automatic t_sample_point();
    do_reset();
    forced = 1'b0; en = 1'b1;
    @(posedge clk); @(negedge clk);
    forced = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check_eq("R8 first-edge level wins", int'(tap_sel), 1);
    run_round("R8 next round", 1, 0);
    en = 1'b0;
  endtask

  task automatic t_lock();
    for (int p = 0; p < TAPS; p++) begin
      int  cyc;
      bit  hit;
      bit  all_in;
      bit  seen_lo;
      bit  seen_hi;
      int  lo;
      do_reset();
      phase = p; model_on = 1'b1; en = 1'b1;
      lo  = (p + TAPS - 1) % TAPS;
      cyc = 0; hit = 1'b0;
      while (cyc < LOCK_LIMIT && !hit) begin
        @(posedge clk); @(negedge clk);
        cyc++;
        hit = (int'(tap_sel) == p) || (int'(tap_sel) == lo);
      end
      check_eq($sformatf("R9 reach window phase %0d", p), int'(hit), 1);
      all_in = 1'b1; seen_lo = 1'b0; seen_hi = 1'b0;
      for (int i = 0; i < 8 * RND; i++) begin
        @(posedge clk); @(negedge clk);
        if (int'(tap_sel) == p)       seen_hi = 1'b1;
        else if (int'(tap_sel) == lo) seen_lo = 1'b1;
        else                          all_in = 1'b0;
      end
      check_eq($sformatf("R9 stays and toggles phase %0d", p),
               int'(all_in && seen_lo && seen_hi), 1);
      en = 1'b0; model_on = 1'b0;
    end
  endtask

  initial begin
    t_reset();
    t_up_down();
    t_wrap();
    t_hold();
    t_sample_point();
    t_lock();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule